// File: doc/BRIEF.md
# Audio Serial Port Master Clock Generator

This block derives the bit clock and the frame clock of an audio serial port running as clock master, by dividing a fast reference clock. A single packed control word sets three things: whether the generator runs, whether frames use two-channel word-select framing or multi-slot single-pulse framing, and two dividers. One divider gives reference cycles per bit clock. The other gives bit clocks per frame. Software works out the divider values from the sample width, the sample rate and the channel count. For example, 16-bit stereo needs 32 bit clocks per frame and 32-bit stereo needs 64. Each doubling of the channel count doubles the frame divider and halves the bit divider.

Besides the two clocks, the block gives the serializers two single-cycle strobes in the reference domain. One marks every rising bit-clock edge and the other marks the first reference cycle of each frame. A control word written while the generator runs is held off until the current frame ends, so a frame never mixes two configurations. Clearing the enable bit stops both clocks at once.

Top module: `i2s_tdm_clkgen`

## Requirements
- R1: Control word bit 0 is enable and bit 1 selects multi-slot framing. The default layout puts the frame divider in bits 10:2 and the bit divider in bits 23:11. With parameter WIDE_FRAME=1 the frame divider is in bits 12:2 and the bit divider is in bits 23:13.
- R2: With bit divider B, each bit-clock period lasts B reference cycles. The low phase (B - floor(B/2) cycles) comes first, then the high phase (floor(B/2) cycles). A divider value below 2 acts as 2.
- R3: bclk_rise is high for exactly the first reference cycle in which bclk is high in each bit period.
- R4: In word-select framing with frame divider F, fclk is low for bit indices 0 to floor(F/2)-1 and high for the remaining bits of the frame. It changes only together with a falling bit-clock edge.
- R5: In multi-slot framing, fclk is high for the whole of bit index 0 of each frame and low for all other bits.
- R6: frame_start is high for exactly the first reference cycle of every frame, while bclk is low. A frame divider value below 2 acts as 2.
- R7: While running, a changed control word (mode or either divider) takes effect only from the first cycle of the next frame.
- R8: A cycle in which the enable bit is sampled low drives all four outputs low from the next cycle on. A later re-enable starts a fresh frame at bit 0 one cycle after the enable is sampled high, using the control word sampled then.
- R9: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 24 | Packed enable, framing mode and dividers |
| bclk | output | 1 | Bit clock |
| fclk | output | 1 | Frame clock (word select or frame sync) |
| bclk_rise | output | 1 | One-cycle strobe at each rising bit-clock edge |
| frame_start | output | 1 | One-cycle strobe at the first cycle of each frame |

## Verification
The bench targets odd bit dividers. A design that split the cycles the wrong way would move the rising edge, and the bclk_rise strobe would come one cycle early or late. It also uses divider values of 0 and 1, which would hang or stall the counters if they were not clamped. It rewrites the control word in the middle of a frame, where a design that adopted the new word at once would cut the frame short and break the frame rhythm. It also drops the enable mid-frame and raises it again, where any stale counter state would start the next frame at the wrong bit. Large dividers run on both field layouts, so a mis-sliced field shows up as a wrong period.

// File: rtl/i2s_tdm_clkgen.sv
module i2s_tdm_clkgen #(
  parameter bit WIDE_FRAME = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:0] ctrl_word,
  output logic        bclk,
  output logic        fclk,
  output logic        bclk_rise,
  output logic        frame_start
);
  localparam int FW  = WIDE_FRAME ? 11 : 9;
  localparam int BW  = WIDE_FRAME ? 11 : 13;
  localparam int FLO = 2;
  localparam int FHI = FLO + FW - 1;
  localparam int BLO = FHI + 1;
  localparam int BHI = BLO + BW - 1;

  logic          run_q, run_d;
  logic          tdm_q, tdm_d;
  logic [BW-1:0] bdiv_q, bdiv_d, rc_q, rc_d;
  logic [FW-1:0] fdiv_q, fdiv_d, bc_q, bc_d;

  wire [BW-1:0] b_in  = ctrl_word[BHI:BLO];
  wire [FW-1:0] f_in  = ctrl_word[FHI:FLO];
  wire [BW-1:0] b_new = (b_in < BW'(2)) ? BW'(2) : b_in;
  wire [FW-1:0] f_new = (f_in < FW'(2)) ? FW'(2) : f_in;

  wire bit_end   = rc_q == bdiv_q - BW'(1);
  wire frame_end = bit_end && (bc_q == fdiv_q - FW'(1));

  always_comb begin
    run_d  = run_q;
    tdm_d  = tdm_q;
    bdiv_d = bdiv_q;
    fdiv_d = fdiv_q;
    rc_d   = rc_q + BW'(1);
    bc_d   = bc_q;
    if (!ctrl_word[0] || !run_q || frame_end) begin
      run_d  = ctrl_word[0];
      tdm_d  = ctrl_word[1];
      bdiv_d = b_new;
      fdiv_d = f_new;
      rc_d   = '0;
      bc_d   = '0;
    end else if (bit_end) begin
      rc_d = '0;
      bc_d = bc_q + FW'(1);
    end
  end

  wire [BW-1:0] low_len = bdiv_d - (bdiv_d >> 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q       <= 1'b0;
      tdm_q       <= 1'b0;
      bdiv_q      <= BW'(2);
      fdiv_q      <= FW'(2);
      rc_q        <= '0;
      bc_q        <= '0;
      bclk        <= 1'b0;
      fclk        <= 1'b0;
      bclk_rise   <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      run_q       <= run_d;
      tdm_q       <= tdm_d;
      bdiv_q      <= bdiv_d;
      fdiv_q      <= fdiv_d;
      rc_q        <= rc_d;
      bc_q        <= bc_d;
      bclk        <= run_d && (rc_d >= low_len);
      bclk_rise   <= run_d && (rc_d == low_len);
      frame_start <= run_d && (rc_d == '0) && (bc_d == '0);
      fclk        <= run_d && (tdm_d ? (bc_d == '0) : (bc_d >= (fdiv_d >> 1)));
    end
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[0] |=> (!bclk && !fclk && !bclk_rise && !frame_start)); // R8
  AST_RISE_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> bclk_rise); // R3
  AST_RISE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_rise |-> bclk); // R3
  AST_FCLK_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fclk != $past(fclk)) |-> !bclk); // R4
  AST_FS_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (!bclk && !bclk_rise)); // R6
endmodule

// File: tb/tb_i2s_tdm_clkgen.sv
module tb_i2s_tdm_clkgen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [23:0] ctrl0 = '0, ctrl1 = '0;
  logic bclk0, fclk0, rise0, fs0;
  logic bclk1, fclk1, rise1, fs1;

  always #4 clk = ~clk;

  i2s_tdm_clkgen #(.WIDE_FRAME(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl0),
    .bclk(bclk0), .fclk(fclk0), .bclk_rise(rise0), .frame_start(fs0));
  i2s_tdm_clkgen #(.WIDE_FRAME(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl1),
    .bclk(bclk1), .fclk(fclk1), .bclk_rise(rise1), .frame_start(fs1));

  int tests = 0, fails = 0, cyc = 0;
  bit checking = 1'b0, done = 1'b0;
  string tag = "R9";

  int req_en = 0, req_tdm = 0, req_b = 2, req_f = 2;
  int m_run = 0, m_rc = 0, m_bc = 0, m_b = 2, m_f = 2, m_tdm = 0;
  bit e_bclk = 0, e_fclk = 0, e_rise = 0, e_fs = 0;

  task automatic set_cfg(input int en, input int tdm, input int b, input int f);
    req_en = en; req_tdm = tdm; req_b = b; req_f = f;
    ctrl0 = {b[12:0], f[8:0], tdm[0], en[0]};
    ctrl1 = {b[10:0], f[10:0], tdm[0], en[0]};
  endtask

  task automatic model_load();
    m_b = (req_b < 2) ? 2 : req_b;
    m_f = (req_f < 2) ? 2 : req_f;
    m_tdm = req_tdm;
    m_rc = 0;
    m_bc = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_run = 0; m_rc = 0; m_bc = 0;
    end else begin
      if (req_en == 0) begin
        m_run = 0; model_load();
      end else if (m_run == 0) begin
        m_run = 1; model_load();
      end else if (m_rc == m_b - 1) begin
        if (m_bc == m_f - 1) model_load();
        else begin m_rc = 0; m_bc++; end
      end else m_rc++;
    end
    e_bclk = m_run != 0 && m_rc >= m_b - m_b / 2;
    e_rise = m_run != 0 && m_rc == m_b - m_b / 2;
    e_fs   = m_run != 0 && m_rc == 0 && m_bc == 0;
    e_fclk = m_run != 0 && ((m_tdm != 0) ? (m_bc == 0) : (m_bc >= m_f / 2));
    if (cyc >= 190000 && !done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string rq, input int lay, input bit got, input bit exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s (%s) layout%0d cycle %0d got %b exp %b", rq, tag, lay, cyc, got, exp);
    end
  endtask

  always @(negedge clk) if (checking) begin
    chk("R2 bclk", 0, bclk0, e_bclk);
    chk("R2 bclk", 1, bclk1, e_bclk);
    chk("R3 bclk_rise", 0, rise0, e_rise);
    chk("R3 bclk_rise", 1, rise1, e_rise);
    chk(m_tdm != 0 ? "R5 fclk" : "R4 fclk", 0, fclk0, e_fclk);
    chk(m_tdm != 0 ? "R5 fclk" : "R4 fclk", 1, fclk1, e_fclk);
    chk("R6 frame_start", 0, fs0, e_fs);
    chk("R6 frame_start", 1, fs1, e_fs);
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    set_cfg(1, 0, 4, 8);
    repeat (3) @(posedge clk);
    #1;
    tag = "R9 reset";
    chk("R9 outputs in reset", 0, bclk0 | fclk0 | rise0 | fs0, 1'b0);
    chk("R9 outputs in reset", 1, bclk1 | fclk1 | rise1 | fs1, 1'b0);
    @(negedge clk);
    set_cfg(0, 0, 4, 8);
    rst_n = 1'b1;
    checking = 1'b1;
    wait_cyc(4);

    tag = "R4 stereo word select"; set_cfg(1, 0, 4, 32); wait_cyc(400);
    tag = "R2 odd divider";        set_cfg(1, 0, 5, 8);  wait_cyc(300);
    tag = "R4 odd frame";          set_cfg(1, 0, 3, 7);  wait_cyc(200);
    tag = "R5 multi-slot";         set_cfg(1, 1, 6, 8);  wait_cyc(300);
    tag = "R5 two-cycle bits";     set_cfg(1, 1, 2, 16); wait_cyc(150);

    tag = "R7 mid-frame rewrite";
    set_cfg(1, 0, 4, 16); wait_cyc(150);
    set_cfg(1, 1, 3, 4);  wait_cyc(20);
    set_cfg(1, 0, 7, 6);  wait_cyc(15);
    set_cfg(1, 1, 5, 10); wait_cyc(300);

    tag = "R2 R6 clamp low dividers";
    set_cfg(1, 0, 0, 1); wait_cyc(60);
    set_cfg(1, 1, 1, 0); wait_cyc(60);

    tag = "R8 disable mid-frame";
    set_cfg(1, 0, 6, 12); wait_cyc(37);
    set_cfg(0, 0, 6, 12); wait_cyc(10);
    set_cfg(1, 1, 4, 6);  wait_cyc(100);
    set_cfg(0, 1, 4, 6);  wait_cyc(1);
    set_cfg(1, 0, 3, 4);  wait_cyc(80);

    tag = "R1 large bit divider";   set_cfg(1, 0, 2000, 3); wait_cyc(6100);
    tag = "R1 large frame divider"; set_cfg(1, 1, 2, 500);  wait_cyc(1100);
    tag = "R1 32-bit stereo 192k";  set_cfg(1, 0, 16, 64);  wait_cyc(2100);
    tag = "R1 16-bit stereo 8k";    set_cfg(1, 0, 768, 32); wait_cyc(24700);
    tag = "R1 8ch multi-slot";      set_cfg(1, 1, 8, 256);  wait_cyc(4200);

    checking = 1'b0;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule